// File: doc/BRIEF.md
# Strided Complement-Fill Memory Self-Test Controller

This controller runs a cache-insensitive memory test over a single-port SRAM with a one-cycle read latency. The address space is split into residue classes of a fixed stride, 20 by default. For each class in turn, the controller runs four kinds of pass. The first marks every location of the class with a test pattern. The next passes fill every other location with the pattern's complement, and this complement fill is repeated a set number of times. The last pass reads back only the locations of the class and compares them against the pattern. Every pass sweeps the whole address range before the next one starts. Between a write to a location and its read-back, the complement writes to all other locations push out any buffered data.

A single `start` pulse runs the full sweep. The sweep covers every residue, and it is repeated for every pattern of the selected pattern family. `busy` is high while the sweep runs. `done` rises at the end and holds until the next start. A mismatch sets a sticky `fail` flag and records the address and the read data of the first bad location.

Top module: `mxt_stride_tester`

## Requirements
- R1: After reset, `busy`, `done` and `fail` are 0. `mem_en` is 0 whenever `busy` is 0.
- R2: A `start` sampled high while not busy begins a run in the next cycle. For each pattern, offsets 0 to STRIDE-1 are taken in ascending order. For each offset the controller runs one pattern pass, then REPEAT complement passes, then one check pass. Each pass steps through addresses 0 to DEPTH-1, one address per cycle, in ascending order.
- R3: A pattern pass writes the pattern (`mem_en`=1, `mem_we`=1) only where (address - offset) mod STRIDE = 0. It makes no access at any other address.
- R4: A complement pass writes the bitwise inverse of the pattern at every address that is not in the current residue class. It makes no access at the class members. This pass runs REPEAT times in a row, with REPEAT ≥ 1.
- R5: A check pass issues reads (`mem_en`=1, `mem_we`=0) only at class members. The controller compares `mem_rdata`, taken one cycle after each read, against the pattern.
- R6: With `pat_mode`=0 the patterns are all-zeros and then all-ones. With `pat_mode`=1 the patterns are a single one bit at bit position 0, 1, …, DATA_W-1, in that order. The mode is captured at start.
- R7: A mismatch sets `fail`, which stays set until the next accepted start. `err_addr` and `err_data` hold the address and read data of the first mismatch of the run.
- R8: `busy` stays high for exactly P·STRIDE·(REPEAT+2)·DEPTH + 1 cycles. P is 2 for mode 0 and DATA_W for mode 1. The final cycle lets the last read be compared. After that `done` is 1 and `busy` is 0 until the next start. `done` is never high together with `busy`.
- R9: A `start` pulse while `busy` is high is ignored. The run goes on unchanged.
- R10: On a fault-free memory, `fail` stays 0 for a whole run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a run (ignored while busy) |
| pat_mode | input | 1 | 0: solid zeros/ones, 1: walking one |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |
| fail | output | 1 | Sticky mismatch flag |
| err_addr | output | ADDR_W | Address of first mismatch |
| err_data | output | DATA_W | Read data of first mismatch |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 1 | Write enable (1 write, 0 read) |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Write data |
| mem_rdata | input | DATA_W | Read data, valid one cycle after a read |

## Verification
The assertions check several rules on every cycle. A strided location must agree with the residue of its address, computed by a modulo. Walking patterns must be one-hot and solid patterns must be all-zeros or all-ones. The fail flag and the first error record must stay put once set. There must be no memory access while idle, `done` and `busy` must never be high together, and a start during a run must not end that run. Other properties can only be shown by the bench's scenarios. These are the exact access order across all residues, patterns and repeats, the exact run length, the first-error capture against an injected stuck bit, and the clearing of `fail` on a later start.

// File: rtl/mxt_pkg.sv
// Package: shared types for the strided complement-fill memory tester.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package mxt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FILL,
        ST_COMP,
        ST_CHECK,
        ST_DRAIN,
        ST_DONE
    } mxt_state_e;
endpackage

// File: rtl/mxt_addr_walker.sv
// Module: mxt_addr_walker
// Steps the address through 0..DEPTH-1, one address per step. It keeps a
// residue counter that wraps at STRIDE, so class membership needs no divider.
// Assumes: STRIDE >= 2. load_off is the offset of the pass that follows a wrap.
module mxt_addr_walker #(
    parameter int DEPTH  = 64,
    parameter int STRIDE = 20,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int OFF_W  = $clog2(STRIDE)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              step,
    input  logic              active,
    input  logic [OFF_W-1:0]  cur_off,
    input  logic [OFF_W-1:0]  load_off,
    output logic [ADDR_W-1:0] addr,
    output logic              member,
    output logic              last
);
    logic [OFF_W-1:0] res_q;
    logic [OFF_W-1:0] res_init;

    // Residue of address 0 for the next offset: (0 - off) mod STRIDE.
    always_comb begin
        res_init = (load_off == '0) ? '0 : (OFF_W'(STRIDE) - load_off);
    end

    // Address and residue counters.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            addr  <= '0;
            res_q <= '0;
        end else if (step) begin
            if (last) begin
                addr  <= '0;
                res_q <= res_init;
            end else begin
                addr  <= addr + 1'b1;
                res_q <= (res_q == OFF_W'(STRIDE - 1)) ? '0 : res_q + 1'b1;
            end
        end
    end

    // Decodes class membership and the end of a pass.
    always_comb begin
        member = (res_q == '0);
        last   = (addr == ADDR_W'(DEPTH - 1));
    end

    // R3: membership agrees with the arithmetic residue of the address.
    p_member_residue_r3: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (member == ((int'(addr) % STRIDE) == int'(cur_off))));
endmodule

// File: rtl/mxt_pattern_gen.sv
// Module: mxt_pattern_gen
// Produces the current test pattern and moves to the next one on request.
// Mode 0 gives all-zeros and then all-ones. Mode 1 gives a one-hot bit that
// walks up from bit 0. The mode is captured on clear.
// Assumes: DATA_W >= 2.
module mxt_pattern_gen #(
    parameter int DATA_W = 8,
    localparam int PIDX_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              mode_in,
    input  logic              advance,
    input  logic              active,
    output logic [DATA_W-1:0] pattern,
    output logic              last_pat
);
    logic              mode_q;
    logic [PIDX_W-1:0] idx_q;

    // Captures the mode and steps the pattern index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= 1'b0;
            idx_q  <= '0;
        end else if (clear) begin
            mode_q <= mode_in;
            idx_q  <= '0;
        end else if (advance) begin
            idx_q <= idx_q + 1'b1;
        end
    end

    // Maps the index to a pattern value and flags the final pattern.
    always_comb begin
        if (mode_q) begin
            pattern  = DATA_W'(1) << idx_q;
            last_pat = (idx_q == PIDX_W'(DATA_W - 1));
        end else begin
            pattern  = {DATA_W{idx_q[0]}};
            last_pat = idx_q[0];
        end
    end

    // R6: a walking pattern is one-hot.
    p_walk_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && mode_q) |-> ($countones(pattern) == 1));
    // R6: a solid pattern is uniform.
    p_solid_uniform_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !mode_q) |-> (pattern == '0 || pattern == '1));
endmodule

// File: rtl/mxt_read_checker.sv
// Module: mxt_read_checker
// Keeps the address and expected value of each issued read. It compares the
// returned data one cycle later and holds the first mismatch and a sticky flag.
// Assumes: the memory returns read data exactly one cycle after the read.
module mxt_read_checker #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              issue,
    input  logic [ADDR_W-1:0] issue_addr,
    input  logic [DATA_W-1:0] expect_val,
    input  logic [DATA_W-1:0] rdata,
    output logic              fail,
    output logic [ADDR_W-1:0] err_addr,
    output logic [DATA_W-1:0] err_data
);
    logic              pend_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] exp_q;
    logic              mism;

    // Holds the context of the read that is in flight.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            pend_q <= 1'b0;
            addr_q <= '0;
            exp_q  <= '0;
        end else begin
            pend_q <= issue;
            if (issue) begin
                addr_q <= issue_addr;
                exp_q  <= expect_val;
            end
        end
    end

    // Compares the returned data against the expected value.
    always_comb begin
        mism = pend_q && (rdata != exp_q);
    end

    // Sticky flag and first-error record.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            fail     <= 1'b0;
            err_addr <= '0;
            err_data <= '0;
        end else if (mism && !fail) begin
            fail     <= 1'b1;
            err_addr <= addr_q;
            err_data <= rdata;
        end
    end

    // R7: the fail flag holds until cleared.
    p_fail_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clear) |=> fail);
    // R7: the first error record is not overwritten.
    p_first_err_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !clear) |=> ($stable(err_addr) && $stable(err_data)));
endmodule

// File: rtl/mxt_stride_tester.sv
// Module: mxt_stride_tester (top)
// Runs the strided memory test. For each pattern and each offset it runs a
// pattern pass, REPEAT complement passes and a check pass over the SRAM.
// Assumes: single-port SRAM with one-cycle read latency. REPEAT >= 1,
// STRIDE >= 2, DEPTH >= 2.
module mxt_stride_tester #(
    parameter int DEPTH  = 64,
    parameter int DATA_W = 8,
    parameter int STRIDE = 20,
    parameter int REPEAT = 2,
    localparam int ADDR_W = $clog2(DEPTH),
    localparam int OFF_W  = $clog2(STRIDE),
    localparam int REP_W  = $clog2(REPEAT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              pat_mode,
    output logic              busy,
    output logic              done,
    output logic              fail,
    output logic [ADDR_W-1:0] err_addr,
    output logic [DATA_W-1:0] err_data,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata
);
    import mxt_pkg::*;

    mxt_state_e        state_q, state_d;
    logic [OFF_W-1:0]  off_q, off_d;
    logic [REP_W-1:0]  rep_q, rep_d;
    logic              clear, step, pass_end, pat_adv;
    logic [ADDR_W-1:0] w_addr;
    logic              w_member, w_last;
    logic [DATA_W-1:0] pattern;
    logic              last_pat;

    // Pass activity and run-start decode.
    always_comb begin
        step     = (state_q == ST_FILL) || (state_q == ST_COMP) || (state_q == ST_CHECK);
        pass_end = step && w_last;
        clear    = start && ((state_q == ST_IDLE) || (state_q == ST_DONE));
    end

    // Next-state, offset and repeat sequencing.
    always_comb begin
        state_d = state_q;
        off_d   = off_q;
        rep_d   = rep_q;
        pat_adv = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_DONE: begin
                if (clear) begin
                    state_d = ST_FILL;
                    off_d   = '0;
                    rep_d   = '0;
                end
            end
            ST_FILL: begin
                if (pass_end) begin
                    state_d = ST_COMP;
                    rep_d   = '0;
                end
            end
            ST_COMP: begin
                if (pass_end) begin
                    if (rep_q == REP_W'(REPEAT - 1)) begin
                        state_d = ST_CHECK;
                    end else begin
                        rep_d = rep_q + 1'b1;
                    end
                end
            end
            ST_CHECK: begin
                if (pass_end) begin
                    if (off_q == OFF_W'(STRIDE - 1)) begin
                        off_d = '0;
                        if (last_pat) begin
                            state_d = ST_DRAIN;
                        end else begin
                            pat_adv = 1'b1;
                            state_d = ST_FILL;
                        end
                    end else begin
                        off_d   = off_q + 1'b1;
                        state_d = ST_FILL;
                    end
                end
            end
            ST_DRAIN: state_d = ST_DONE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Sequencer registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            off_q   <= '0;
            rep_q   <= '0;
        end else begin
            state_q <= state_d;
            off_q   <= off_d;
            rep_q   <= rep_d;
        end
    end

    mxt_addr_walker #(
        .DEPTH  (DEPTH),
        .STRIDE (STRIDE)
    ) u_walker (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .step     (step),
        .active   (step),
        .cur_off  (off_q),
        .load_off (off_d),
        .addr     (w_addr),
        .member   (w_member),
        .last     (w_last)
    );

    mxt_pattern_gen #(
        .DATA_W (DATA_W)
    ) u_patgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (clear),
        .mode_in  (pat_mode),
        .advance  (pat_adv),
        .active   (step),
        .pattern  (pattern),
        .last_pat (last_pat)
    );

    // Memory port drive for the current pass.
    always_comb begin
        mem_addr  = w_addr;
        mem_we    = (state_q == ST_FILL) || (state_q == ST_COMP);
        mem_en    = ((state_q == ST_FILL)  &&  w_member) ||
                    ((state_q == ST_COMP)  && !w_member) ||
                    ((state_q == ST_CHECK) &&  w_member);
        mem_wdata = (state_q == ST_COMP) ? ~pattern : pattern;
    end

    mxt_read_checker #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_check (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (clear),
        .issue      ((state_q == ST_CHECK) && w_member),
        .issue_addr (w_addr),
        .expect_val (pattern),
        .rdata      (mem_rdata),
        .fail       (fail),
        .err_addr   (err_addr),
        .err_data   (err_data)
    );

    // Status outputs.
    always_comb begin
        busy = (state_q != ST_IDLE) && (state_q != ST_DONE);
        done = (state_q == ST_DONE);
    end

    // R1: no memory access outside a run.
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_en);
    // R5: reads occur only in a check pass.
    p_read_in_check_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |-> (state_q == ST_CHECK));
    // R8: done and busy are exclusive.
    p_done_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R9: a start during a pass does not end the run.
    p_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && start) |=> busy);
endmodule

// File: tb/mxt_stride_tester_tb.sv
// Bench: scoreboard of expected memory transactions against a behavioural SRAM.
module mxt_stride_tester_tb;
    localparam int DEPTH  = 64;
    localparam int DATA_W = 8;
    localparam int STRIDE = 20;
    localparam int REPEAT = 2;
    localparam int ADDR_W = $clog2(DEPTH);
    localparam int FAULT_ADDR = 45;
    localparam logic [DATA_W-1:0] FAULT_MASK = 8'h08;

    typedef struct packed {
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } txn_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic pat_mode = 1'b0;
    logic busy, done, fail, mem_en, mem_we;
    logic [ADDR_W-1:0] err_addr, mem_addr;
    logic [DATA_W-1:0] err_data, mem_wdata;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic fault_on = 1'b0;
    logic [DATA_W-1:0] mem [DEPTH];

    txn_t exp_q[$];
    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    mxt_stride_tester #(
        .DEPTH (DEPTH), .DATA_W (DATA_W), .STRIDE (STRIDE), .REPEAT (REPEAT)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .start (start), .pat_mode (pat_mode),
        .busy (busy), .done (done), .fail (fail),
        .err_addr (err_addr), .err_data (err_data),
        .mem_en (mem_en), .mem_we (mem_we), .mem_addr (mem_addr),
        .mem_wdata (mem_wdata), .mem_rdata (mem_rdata)
    );

    // Behavioural SRAM, one-cycle read latency, optional stuck-at-1 bit.
    always @(posedge clk) begin
        if (mem_en && mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_en && !mem_we)
            mem_rdata <= mem[mem_addr] |
                ((fault_on && mem_addr == ADDR_W'(FAULT_ADDR)) ? FAULT_MASK : '0);
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Monitor: pops one expected transaction per memory access (R2 R3 R4 R5).
    always @(negedge clk) begin
        if (rst_n && mem_en) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2 unexpected access", longint'(mem_addr), -1);
            end else begin
                txn_t e;
                e = exp_q.pop_front();
                check(mem_we == e.we && mem_addr == e.addr, "R2/R3/R4/R5 access order",
                      longint'({mem_we, mem_addr}), longint'({e.we, e.addr}));
                if (e.we)
                    check(mem_wdata == e.data, "R3/R4/R6 write data",
                          longint'(mem_wdata), longint'(e.data));
            end
        end
    end

    function automatic logic [DATA_W-1:0] pat_of(input logic mode, input int k);
        return mode ? (DATA_W'(1) << k) : {DATA_W{k[0]}};
    endfunction

    // Driver: expected transaction stream for one run (R2..R6).
    task automatic push_run(input logic mode);
        int np = mode ? DATA_W : 2;
        for (int p = 0; p < np; p++) begin
            logic [DATA_W-1:0] pv = pat_of(mode, p);
            for (int o = 0; o < STRIDE; o++) begin
                for (int a = 0; a < DEPTH; a++)
                    if (a % STRIDE == o) exp_q.push_back('{1'b1, ADDR_W'(a), pv});
                for (int r = 0; r < REPEAT; r++)
                    for (int a = 0; a < DEPTH; a++)
                        if (a % STRIDE != o) exp_q.push_back('{1'b1, ADDR_W'(a), ~pv});
                for (int a = 0; a < DEPTH; a++)
                    if (a % STRIDE == o) exp_q.push_back('{1'b0, ADDR_W'(a), '0});
            end
        end
    endtask

    task automatic run_wait(input logic mode, output int cyc);
        @(negedge clk); start = 1'b1; pat_mode = mode;
        @(negedge clk); start = 1'b0;
        cyc = 0;
        while (!done && cyc < 60000) begin
            if (busy) cyc++;
            @(negedge clk);
        end
    endtask

    task automatic late_start();
        repeat (500) @(negedge clk);
        start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    // Watchdog.
    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        int cyc;
        int n0 = 2 * STRIDE * (REPEAT + 2) * DEPTH + 1;
        int n1 = DATA_W * STRIDE * (REPEAT + 2) * DEPTH + 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check(!busy, "R1 busy", busy, 0);
        check(!done, "R1 done", done, 0);
        check(!fail, "R1 fail", fail, 0);
        check(!mem_en, "R1 mem_en", mem_en, 0);

        // Clean run, solid patterns.
        push_run(1'b0);
        run_wait(1'b0, cyc);
        check(cyc == n0, "R8 run length mode0", cyc, n0);
        check(done && !busy, "R8 done held", {done, busy}, 2);
        check(!fail, "R10 clean run fail", fail, 0);
        check(exp_q.size() == 0, "R2 all accesses seen", exp_q.size(), 0);

        // Faulty run: stuck bit 3 at address 45, first hit at offset 5, zeros.
        fault_on = 1'b1;
        push_run(1'b0);
        run_wait(1'b0, cyc);
        check(fail, "R7 fail set", fail, 1);
        check(err_addr == ADDR_W'(FAULT_ADDR), "R7 err_addr", err_addr, FAULT_ADDR);
        check(err_data == FAULT_MASK, "R7 err_data", err_data, FAULT_MASK);
        check(exp_q.size() == 0, "R5 all reads seen", exp_q.size(), 0);
        repeat (10) @(negedge clk);
        check(fail && done && !mem_en, "R7 sticky while idle", {fail, done, mem_en}, 6);

        // Clean walking run with a start pulse mid-run.
        fault_on = 1'b0;
        push_run(1'b1);
        fork
            run_wait(1'b1, cyc);
            late_start();
        join
        check(cyc == n1, "R9 start ignored (run length)", cyc, n1);
        check(!fail, "R7 fail cleared by start", fail, 0);
        check(exp_q.size() == 0, "R6 walking patterns seen", exp_q.size(), 0);
        check(done, "R8 done after walk", done, 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule